// File: doc/BRIEF.md
# Waveform and Sign-Bit Output Selector

This block sits directly behind a phase accumulator. It turns the truncated phase word into the code for a 10-bit DAC. In sine mode the phase goes out unchanged as the address of an external sine lookup table, and the table's answer is registered as the DAC code. In triangle mode the block folds the phase into a linear up/down ramp. A power-down input parks the DAC code at midscale. The phase path keeps running while it does.

A second path drives one digital pin with a separate output enable. The pin can carry one of three signals:
- the phase MSB,
- the phase MSB divided by two through a toggle stage,
- an external comparator result.

Some combinations of the four configuration bits are illegal. For those the block raises an error flag and drives the pin low. All outputs except the table address are registered, so they show the inputs of the previous clock edge.

Top module: `wave_out_sel`

## Requirements
- R1: While `rst_n` is low at a clock edge, the outputs after that edge are: `dac_code_o` = 512 (midscale), `sign_o` = 0, `sign_oe_o` = 0, `cfg_err_o` = 0. The divide-by-two stage and the stored MSB are cleared.
- R2: `sine_addr_o` always equals `phase_i` in the same cycle. With `wave_tri_i`=0 and `dac_pd_i`=0, `dac_code_o` after an edge equals `sine_data_i` sampled at that edge.
- R3: With `wave_tri_i`=1 and `dac_pd_i`=0, `dac_code_o` after an edge depends on the phase p sampled at that edge. For p < 2048 it is p/2. For p >= 2048 it is (4095-p)/2, using integer division.
- R4: With `dac_pd_i`=1, `dac_code_o` after the edge is 512. The sign path and the divider keep operating unchanged.
- R5: With `pin_en_i`=0, after the edge `sign_oe_o`=0, `sign_o`=0 and `cfg_err_o`=0.
- R6: With `pin_en_i`=1, `wave_tri_i`=0, `cmp_sel_i`=0 and `div2_i`=1, `sign_o` after the edge equals `phase_i[11]` sampled at that edge.
- R7: The divider flips at every edge where `phase_i[11]` is 1 and was 0 at the previous edge. It runs in all modes. With `pin_en_i`=1, `wave_tri_i`=0, `cmp_sel_i`=0 and `div2_i`=0, `sign_o` shows the divider value after that edge's update.
- R8: With `pin_en_i`=1, `wave_tri_i`=0, `cmp_sel_i`=1 and `div2_i`=1, `sign_o` after the edge equals `cmp_i` sampled at that edge.
- R9: With `pin_en_i`=1, `wave_tri_i`=0, `cmp_sel_i`=1 and `div2_i`=0, the combination is reserved. After the edge `cfg_err_o`=1, `sign_o`=0 and `sign_oe_o`=1.
- R10: With `pin_en_i`=1 and `wave_tri_i`=1, the combination is reserved. After the edge `cfg_err_o`=1, `sign_o`=0 and `sign_oe_o`=1. With `pin_en_i`=0, triangle mode raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| phase_i | input | 12 | Truncated phase from the accumulator |
| wave_tri_i | input | 1 | 1 selects triangle, 0 selects sine |
| pin_en_i | input | 1 | Enables the digital sign pin |
| cmp_sel_i | input | 1 | 1 routes the comparator to the pin |
| div2_i | input | 1 | 1 sends the MSB straight, 0 sends the divided MSB |
| cmp_i | input | 1 | Comparator result |
| dac_pd_i | input | 1 | DAC power-down, parks the code at midscale |
| sine_data_i | input | 10 | Amplitude returned by the sine table |
| sine_addr_o | output | 12 | Address to the sine table |
| dac_code_o | output | 10 | Registered DAC code |
| sign_o | output | 1 | Digital pin value |
| sign_oe_o | output | 1 | Pin drive enable; 0 means high impedance |
| cfg_err_o | output | 1 | Reserved configuration flag |

## Verification
The hardest state to reach is the divide-by-two output. Its value is the parity of every MSB rising edge since reset, including edges that pass while the pin is disabled, in another mode, or powered down. So it can only be predicted from the full history.

The stimulus walks through every combination of the five control bits. In each one it steps the phase by several increments: 1, 7, 300 and 2048. An increment of 2048 flips the MSB on every cycle. The bench model counts the rising edges on its own and is compared on every cycle. A reset pulse in the middle of the run checks that the divider clears.

// File: rtl/wave_out_sel.sv
module wave_out_sel #(
  parameter int PHASE_W = 12,
  parameter int DAC_W   = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PHASE_W-1:0] phase_i,
  input  logic               wave_tri_i,
  input  logic               pin_en_i,
  input  logic               cmp_sel_i,
  input  logic               div2_i,
  input  logic               cmp_i,
  input  logic               dac_pd_i,
  input  logic [DAC_W-1:0]   sine_data_i,
  output logic [PHASE_W-1:0] sine_addr_o,
  output logic [DAC_W-1:0]   dac_code_o,
  output logic               sign_o,
  output logic               sign_oe_o,
  output logic               cfg_err_o
);
  localparam logic [DAC_W-1:0] MID = {1'b1, {(DAC_W-1){1'b0}}};

  logic msb_q, half_q, pick;
  logic [DAC_W-1:0] low, tri_code;

  wire msb    = phase_i[PHASE_W-1];
  wire half_n = half_q ^ (msb & ~msb_q);
  wire bad    = pin_en_i & (wave_tri_i | (cmp_sel_i & ~div2_i));

  assign low         = phase_i[PHASE_W-2 -: DAC_W];
  assign tri_code    = msb ? ~low : low;
  assign sine_addr_o = phase_i;

  always_comb begin
    if (cmp_sel_i) pick = cmp_i;
    else if (div2_i) pick = msb;
    else pick = half_n;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msb_q      <= 1'b0;
      half_q     <= 1'b0;
      dac_code_o <= MID;
      sign_o     <= 1'b0;
      sign_oe_o  <= 1'b0;
      cfg_err_o  <= 1'b0;
    end else begin
      msb_q      <= msb;
      half_q     <= half_n;
      dac_code_o <= dac_pd_i ? MID : (wave_tri_i ? tri_code : sine_data_i);
      sign_oe_o  <= pin_en_i;
      cfg_err_o  <= bad;
      sign_o     <= pin_en_i & ~bad & pick;
    end
  end
endmodule

// File: rtl/wave_out_sel_chk.sv
module wave_out_sel_chk #(
  parameter int PHASE_W = 12,
  parameter int DAC_W   = 10
) (
  input logic               clk,
  input logic               rst_n,
  input logic [PHASE_W-1:0] phase_i,
  input logic               wave_tri_i,
  input logic               pin_en_i,
  input logic               cmp_sel_i,
  input logic               div2_i,
  input logic               cmp_i,
  input logic               dac_pd_i,
  input logic [DAC_W-1:0]   dac_code_o,
  input logic               sign_o,
  input logic               sign_oe_o,
  input logic               cfg_err_o
);
  localparam logic [DAC_W-1:0] MID = {1'b1, {(DAC_W-1){1'b0}}};

  p_pd_mid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dac_pd_i |=> dac_code_o == MID);

  p_tri_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!dac_pd_i && wave_tri_i && !phase_i[PHASE_W-1])
      |=> dac_code_o == $past(phase_i[PHASE_W-2 -: DAC_W]));

  p_hiz_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_en_i |=> (!sign_oe_o && !sign_o && !cfg_err_o));

  p_direct_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_en_i && !wave_tri_i && !cmp_sel_i && div2_i)
      |=> sign_o == $past(phase_i[PHASE_W-1]));

  p_cmp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_en_i && !wave_tri_i && cmp_sel_i && div2_i) |=> sign_o == $past(cmp_i));

  p_rsv_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_en_i && !wave_tri_i && cmp_sel_i && !div2_i)
      |=> (cfg_err_o && !sign_o && sign_oe_o));

  p_rsv_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_en_i && wave_tri_i) |=> (cfg_err_o && !sign_o && sign_oe_o));
endmodule

bind wave_out_sel wave_out_sel_chk #(.PHASE_W(PHASE_W), .DAC_W(DAC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .phase_i(phase_i), .wave_tri_i(wave_tri_i),
  .pin_en_i(pin_en_i), .cmp_sel_i(cmp_sel_i), .div2_i(div2_i), .cmp_i(cmp_i),
  .dac_pd_i(dac_pd_i), .dac_code_o(dac_code_o), .sign_o(sign_o),
  .sign_oe_o(sign_oe_o), .cfg_err_o(cfg_err_o)
);

// File: tb/sim_wave_out_sel.sv
module sim_wave_out_sel;
  localparam int PW = 12;
  localparam int DW = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [PW-1:0] phase = '0;
  logic tri_m = 1'b0, en = 1'b0, sel = 1'b0, dv = 1'b0, cmp = 1'b0, pd = 1'b0;
  wire [DW-1:0] sdata, code;
  wire [PW-1:0] addr;
  wire sgn, oe, err;

  always #4 clk = ~clk;

  assign sdata = addr[PW-1:2] ^ 10'h2A5;

  wave_out_sel #(.PHASE_W(PW), .DAC_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .phase_i(phase), .wave_tri_i(tri_m),
    .pin_en_i(en), .cmp_sel_i(sel), .div2_i(dv), .cmp_i(cmp), .dac_pd_i(pd),
    .sine_data_i(sdata), .sine_addr_o(addr), .dac_code_o(code),
    .sign_o(sgn), .sign_oe_o(oe), .cfg_err_o(err)
  );

  int n_chk = 0, n_err = 0, cyc = 0;
  bit done = 0, armed = 0;
  int m_code, p;
  bit m_sign, m_oe, m_err, m_half, m_prev, m_msb;
  string t_code = "R1", t_sig = "R1";

  always @(posedge clk) begin
    if (!rst_n) begin
      m_code = 512; m_sign = 0; m_oe = 0; m_err = 0; m_half = 0; m_prev = 0;
      t_code = "R1"; t_sig = "R1";
    end else begin
      p = int'(phase);
      m_msb = (p >= 2048);
      if (m_msb && !m_prev) m_half = !m_half;
      m_prev = m_msb;
      if (pd) begin m_code = 512; t_code = "R4"; end
      else if (tri_m) begin m_code = m_msb ? (4095 - p) / 2 : p / 2; t_code = "R3"; end
      else begin m_code = (p / 4) ^ 'h2A5; t_code = "R2"; end
      m_oe = en;
      m_err = en && (tri_m || (sel && !dv));
      if (!en) t_sig = "R5";
      else if (tri_m) t_sig = "R10";
      else if (sel && !dv) t_sig = "R9";
      else if (sel) t_sig = "R8";
      else if (dv) t_sig = "R6";
      else t_sig = "R7";
      m_sign = en && !m_err && (sel ? cmp : (dv ? m_msb : m_half));
    end
    armed = 1;
  end

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) if (armed && !done) begin
    chk(t_code, "dac_code", int'(code), m_code);
    chk(t_sig, "sign", int'(sgn), int'(m_sign));
    chk(t_sig, "oe", int'(oe), int'(m_oe));
    chk(t_sig, "err", int'(err), int'(m_err));
    chk("R2", "sine_addr", int'(addr), int'(phase));
  end

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc);
      finish_run();
    end
  end

  task automatic run(int c, int n, int stp);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
      {en, tri_m, sel, dv, pd} = 5'(c);
      phase = phase + PW'(stp);
      cmp = 1'($urandom);
    end
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #2 rst_n = 1'b1;
    run(5'b01000, 4100, 1);
    for (int c = 0; c < 32; c++) begin
      run(c, 60, 1);
      run(c, 60, 7);
      run(c, 60, 300);
      run(c, 60, 2048);
    end
    run(5'b10000, 50, 300);
    @(posedge clk); #2 rst_n = 1'b0;
    run(5'b10001, 3, 2048);
    rst_n = 1'b1;
    run(5'b10000, 200, 300);
    run(5'b00000, 200, 13);
    @(negedge clk);
    finish_run();
  end
endmodule